// File: doc/BRIEF.md
# Chip-Enable Framed Serial Register Interface

This block is the host-facing serial port of a two-digit display driver with a key matrix. A host microcontroller drives a shift clock, a data line and an active-high chip enable; the block answers on one open-drain data-out line, modelled here as a level where 1 means released. Every transfer starts with an 8-bit address byte, clocked in while chip enable is low. The address picks one of three outcomes: a write frame of display and control data, a read frame of key data, or a frame that is ignored.

A full display update takes two write frames that share the write address. A 2-bit direction code at the end of each frame selects the bank. One frame carries the first bank of segment bits together with the dimmer and sleep fields. The other frame carries the second bank. A frame is committed to the working registers only when chip enable falls after exactly the frame length in bits. A read frame shifts out the key bits and then a sleep-acknowledge bit. While chip enable is low, the data-out line shows the key scanner's request for a read.

All serial lines are sampled in the system clock domain, and a line edge is a change seen between two clock samples. Only the synchronous reset clears the interface. A display blanking signal elsewhere does not touch it, so the host can load data while the display is held dark.

Top module: `cef_serial_if`

## Requirements
- R1: While reset is held, and in the cycle after it, both segment banks, the dimmer and the sleep code read zero and data-out is released (1).
- R2: The write address is 8E hex, sent least significant bit first (0,1,1,1,0,0,0,1). A write frame is 64 bits, and the first bit transmitted is frame bit 0. If frame bits 63:62 equal 00, chip enable falling commits bits 40:0 to bank A, bits 50:41 to the dimmer and bits 52:51 to the sleep code.
- R3: If frame bits 63:62 equal 01 (bit 62 set), chip enable falling commits bits 40:0 to bank B. Bank A, the dimmer and the sleep code are unchanged.
- R4: A write frame with direction code 10 or 11 changes nothing.
- R5: A write frame whose bit count is not exactly 64 changes nothing.
- R6: A transfer whose address is neither 8E nor 8F hex changes no register and gives no read-done pulse.
- R7: While chip enable is low, data-out equals the inverse of the scanner's request input, one clock later.
- R8: The read address is 8F hex, sent least significant bit first. After chip enable rises, data-out presents key bit 0 first and moves to the next bit after each falling shift-clock edge. The 31st bit is the sleep acknowledge, which is 1 exactly when the committed sleep code is nonzero.
- R9: If the request input is low when a read frame opens, all 31 bits read back as 0.
- R10: The read-done output pulses for exactly one cycle, one cycle after chip enable falls, and only on a read frame that opened with the request high and received exactly 31 rising shift-clock edges.
- R11: While a write frame is open, data-out stays released (1).
- R12: Bank A, bank B, the dimmer and the sleep code change only in the cycle after chip enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Host shift clock |
| sdi | input | 1 | Host serial data in |
| ce | input | 1 | Chip enable, active high |
| key_req | input | 1 | Scanner asks for a key read |
| key_bits | input | 30 | Debounced key states from the scanner |
| sdo | output | 1 | Open-drain data out level (1 = released) |
| disp_a | output | 41 | Committed segment bank A |
| disp_b | output | 41 | Committed segment bank B |
| dimmer | output | 10 | Committed dimmer value |
| sleep_code | output | 2 | Committed sleep code |
| read_done | output | 1 | One-cycle pulse after a completed read |

## Verification
The bench sends frames of 63 and 65 bits. A design that commits on any chip-enable fall would corrupt bank A on these frames. It sends a bank-B frame with nonzero control fields, which catches a decoder that writes the control fields from either bank. It also sends an unused direction code and a neighbouring address (8D), which would be taken as valid by a decoder that checks too few bits. On the read side, it reads with the request low, which must return zeros with no done pulse. It also cuts a read off at 30 clocks, which must not pulse done. It reads with the sleep code both set and cleared, so a swapped or stuck acknowledge bit shows up. During writes it holds the request high, so a data-out line that leaks the request into an open frame is caught.

// File: rtl/cef_pkg.sv
package cef_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_WRITE = 8'h8E;
  localparam logic [ADDR_W-1:0] ADDR_READ  = 8'h8F;
  localparam logic [1:0] DIR_BANK_A = 2'b00;
  localparam logic [1:0] DIR_BANK_B = 2'b01;

  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_WR   = 2'd1,
    PH_RD   = 2'd2,
    PH_SKIP = 2'd3
  } phase_t;
endpackage

// File: rtl/cef_edge.sv
module cef_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lines,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= lines[i];
    end
    assign rise[i] = lines[i] & ~q[i];
    assign fall[i] = ~lines[i] & q[i];
  end
endmodule

// File: rtl/cef_rx.sv
module cef_rx
  import cef_pkg::*;
#(
  parameter int DISP_W  = 41,
  parameter int DIM_W   = 10,
  parameter int SLP_W   = 2,
  parameter int FRAME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              sdi,
  input  logic              sclk_rise,
  input  logic              ce_rise,
  input  logic              ce_fall,
  output phase_t            phase,
  output logic              rd_open,
  output logic              rd_close,
  output logic [DISP_W-1:0] bank_a,
  output logic [DISP_W-1:0] bank_b,
  output logic [DIM_W-1:0]  dim_q,
  output logic [SLP_W-1:0]  slp_q
);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int DIM_LSB = DISP_W;
  localparam int SLP_LSB = DISP_W + DIM_W;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_W + 1);

  logic [ADDR_W-1:0]  addr_sr;
  logic [FRAME_W-1:0] data_sr;
  logic [CNT_W-1:0]   cnt;
  logic [1:0]         dir;

  assign dir      = data_sr[FRAME_W-1 -: 2];
  assign rd_open  = ce_rise && (addr_sr == ADDR_READ);
  assign rd_close = ce_fall && (phase == PH_RD);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_sr <= '0;
      data_sr <= '0;
      cnt     <= '0;
      phase   <= PH_ADDR;
      bank_a  <= '0;
      bank_b  <= '0;
      dim_q   <= '0;
      slp_q   <= '0;
    end else begin
      if (!ce && sclk_rise) addr_sr <= {sdi, addr_sr[ADDR_W-1:1]};
      if (ce_rise) begin
        cnt     <= '0;
        addr_sr <= '0;
        case (addr_sr)
          ADDR_WRITE: phase <= PH_WR;
          ADDR_READ:  phase <= PH_RD;
          default:    phase <= PH_SKIP;
        endcase
      end else if (ce_fall) begin
        phase <= PH_ADDR;
        if (phase == PH_WR && cnt == CNT_FULL) begin
          case (dir)
            DIR_BANK_A: begin
              bank_a <= data_sr[DISP_W-1:0];
              dim_q  <= data_sr[DIM_LSB +: DIM_W];
              slp_q  <= data_sr[SLP_LSB +: SLP_W];
            end
            DIR_BANK_B: bank_b <= data_sr[DISP_W-1:0];
            default: ;
          endcase
        end
      end else if (ce && sclk_rise && phase == PH_WR) begin
        data_sr <= {sdi, data_sr[FRAME_W-1:1]};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cef_tx.sv
module cef_tx #(
  parameter int KEY_W = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_open,
  input  logic             rd_close,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             key_req,
  input  logic [KEY_W-1:0] keys,
  input  logic             sleep_ack,
  output logic             active,
  output logic             tx_bit,
  output logic             done
);
  localparam int WORD_W = KEY_W + 1;
  localparam int RC_W   = $clog2(KEY_W + 3);
  localparam logic [RC_W-1:0] RC_FULL = RC_W'(WORD_W);
  localparam logic [RC_W-1:0] RC_MAX  = RC_W'(WORD_W + 1);

  logic [WORD_W-1:0] sr;
  logic [RC_W-1:0]   rcnt;
  logic              valid;

  assign tx_bit = sr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      rcnt   <= '0;
      valid  <= 1'b0;
      active <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rd_open) begin
        active <= 1'b1;
        valid  <= key_req;
        sr     <= key_req ? {sleep_ack, keys} : '0;
        rcnt   <= '0;
      end else if (rd_close) begin
        active <= 1'b0;
        done   <= valid && (rcnt == RC_FULL);
      end else if (active) begin
        if (sclk_fall) sr <= {1'b0, sr[WORD_W-1:1]};
        if (sclk_rise && rcnt != RC_MAX) rcnt <= rcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cef_serial_if.sv
module cef_serial_if
  import cef_pkg::*;
#(
  parameter int DISP_W  = 41,
  parameter int DIM_W   = 10,
  parameter int SLP_W   = 2,
  parameter int KEY_W   = 30,
  parameter int FRAME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              ce,
  input  logic              key_req,
  input  logic [KEY_W-1:0]  key_bits,
  output logic              sdo,
  output logic [DISP_W-1:0] disp_a,
  output logic [DISP_W-1:0] disp_b,
  output logic [DIM_W-1:0]  dimmer,
  output logic [SLP_W-1:0]  sleep_code,
  output logic              read_done
);
  logic [1:0] ln_q, ln_rise, ln_fall;
  phase_t     phase;
  logic       rd_open, rd_close, rd_active, tx_bit;
  logic       ce_q_w, wr_phase_w;

  cef_edge #(.W(2)) u_edge (
    .clk(clk), .rst(rst), .lines({ce, sclk}),
    .q(ln_q), .rise(ln_rise), .fall(ln_fall)
  );

  assign ce_q_w     = ln_q[1];
  assign wr_phase_w = (phase == PH_WR);

  cef_rx #(.DISP_W(DISP_W), .DIM_W(DIM_W), .SLP_W(SLP_W), .FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .rst(rst), .ce(ce), .sdi(sdi),
    .sclk_rise(ln_rise[0]), .ce_rise(ln_rise[1]), .ce_fall(ln_fall[1]),
    .phase(phase), .rd_open(rd_open), .rd_close(rd_close),
    .bank_a(disp_a), .bank_b(disp_b), .dim_q(dimmer), .slp_q(sleep_code)
  );

  cef_tx #(.KEY_W(KEY_W)) u_tx (
    .clk(clk), .rst(rst), .rd_open(rd_open), .rd_close(rd_close),
    .sclk_rise(ln_rise[0]), .sclk_fall(ln_fall[0]),
    .key_req(key_req), .keys(key_bits), .sleep_ack(|sleep_code),
    .active(rd_active), .tx_bit(tx_bit), .done(read_done)
  );

  always_ff @(posedge clk) begin
    if (rst)            sdo <= 1'b1;
    else if (!ce)       sdo <= ~key_req;
    else if (rd_active) sdo <= tx_bit;
    else                sdo <= 1'b1;
  end
endmodule

// File: rtl/cef_serial_if_chk.sv
module cef_serial_if_chk #(
  parameter int DISP_W = 41,
  parameter int DIM_W  = 10,
  parameter int SLP_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ce,
  input logic              key_req,
  input logic              sdo,
  input logic [DISP_W-1:0] disp_a,
  input logic [DISP_W-1:0] disp_b,
  input logic [DIM_W-1:0]  dimmer,
  input logic [SLP_W-1:0]  sleep_code,
  input logic              read_done,
  input logic              ce_q,
  input logic              wr_phase
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (disp_a == '0 && disp_b == '0 && dimmer == '0 && sleep_code == '0 && sdo));

  // R7
  a_r7_request_idle: assert property (@(posedge clk) disable iff (rst)
    !ce |=> (sdo == !$past(key_req)));

  // R10
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    read_done |=> !read_done);

  // R10
  a_r10_done_after_fall: assert property (@(posedge clk) disable iff (rst)
    read_done |-> (!$past(ce) && $past(ce_q)));

  // R11
  a_r11_write_released: assert property (@(posedge clk) disable iff (rst)
    (ce && wr_phase) |=> sdo);

  // R12
  a_r12_hold_between: assert property (@(posedge clk) disable iff (rst)
    (ce || !ce_q) |=> ($stable(disp_a) && $stable(disp_b) && $stable(dimmer) && $stable(sleep_code)));
endmodule

bind cef_serial_if cef_serial_if_chk #(.DISP_W(DISP_W), .DIM_W(DIM_W), .SLP_W(SLP_W)) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .key_req(key_req), .sdo(sdo),
  .disp_a(disp_a), .disp_b(disp_b), .dimmer(dimmer), .sleep_code(sleep_code),
  .read_done(read_done), .ce_q(ce_q_w), .wr_phase(wr_phase_w)
);

// File: tb/cef_serial_if_test.sv
module cef_serial_if_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0, sdi = 1'b0, ce = 1'b0, key_req = 1'b0;
  logic [29:0] key_bits = 30'h15A3C96B;
  logic        sdo, read_done;
  logic [40:0] disp_a, disp_b;
  logic [9:0]  dimmer;
  logic [1:0]  sleep_code;

  always #10 clk = ~clk;

  cef_serial_if uut (
    .clk(clk), .rst(rst), .sclk(sclk), .sdi(sdi), .ce(ce), .key_req(key_req),
    .key_bits(key_bits), .sdo(sdo), .disp_a(disp_a), .disp_b(disp_b),
    .dimmer(dimmer), .sleep_code(sleep_code), .read_done(read_done)
  );

  typedef struct {
    string       rq;
    int          sel;
    logic [63:0] exp;
  } item_t;

  item_t       sb_q[$];
  event        sample_ev;
  int          n_vec = 0, n_bad = 0, done_cnt = 0;
  logic [63:0] rd_word;
  logic        wr_sdo_low;
  bit          finished = 0;

  always @(posedge clk) if (!rst && read_done) done_cnt <= done_cnt + 1;

  function automatic logic [63:0] observe(int sel);
    case (sel)
      0: return 64'(disp_a);
      1: return 64'(disp_b);
      2: return 64'(dimmer);
      3: return 64'(sleep_code);
      4: return 64'(sdo);
      5: return rd_word;
      6: return 64'(done_cnt);
      default: return 64'(wr_sdo_low);
    endcase
  endfunction

  // monitor: pops expectations and compares against what the block shows
  initial forever begin
    @(sample_ev);
    while (sb_q.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it  = sb_q.pop_front();
      act = observe(it.sel);
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.rq, act, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_val(string rq, int sel, logic [63:0] e);
    item_t it;
    it.rq = rq; it.sel = sel; it.exp = e;
    sb_q.push_back(it);
    -> sample_ev;
    tick(1);
  endtask

  task automatic send_bit(logic b);
    sdi = b; tick(2);
    sclk = 1'b1; tick(4);
    sclk = 1'b0; tick(2);
  endtask

  task automatic send_addr(logic [7:0] a);
    ce = 1'b0;
    for (int i = 0; i < 8; i++) send_bit(a[i]);
    tick(2);
  endtask

  function automatic logic [63:0] mk_frame(logic [1:0] dir, logic [1:0] slp, logic [9:0] dim, logic [40:0] d);
    return {dir, 9'd0, slp, dim, d};
  endfunction

  task automatic write_frame(logic [7:0] a, logic [63:0] f, int nbits);
    send_addr(a);
    ce = 1'b1; tick(2);
    wr_sdo_low = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      if (!sdo) wr_sdo_low = 1'b1;
      send_bit(i < 64 ? f[i] : 1'b1);
      if (!sdo) wr_sdo_low = 1'b1;
    end
    ce = 1'b0; tick(4);
  endtask

  task automatic read_frame(int nbits);
    send_addr(8'h8F);
    ce = 1'b1; tick(4);
    rd_word = '0;
    for (int i = 0; i < nbits; i++) begin
      rd_word[i] = sdo;
      send_bit(1'b0);
    end
    ce = 1'b0; tick(4);
  endtask

  localparam logic [40:0] PAT_A  = 41'h1_5AA3_3CC0F;
  localparam logic [40:0] PAT_B  = 41'h0_C3E1_7A55;
  localparam logic [40:0] PAT_A2 = 41'h1_0F0F_9669;

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    expect_val("R1 bank A", 0, 64'd0);
    expect_val("R1 bank B", 1, 64'd0);
    expect_val("R1 dimmer", 2, 64'd0);
    expect_val("R1 sleep", 3, 64'd0);
    expect_val("R1 sdo", 4, 64'd1);

    key_req = 1'b1; tick(2);
    expect_val("R7 request shown", 4, 64'd0);
    key_req = 1'b0; tick(2);
    expect_val("R7 request clear", 4, 64'd1);

    key_req = 1'b1;
    write_frame(8'h8E, mk_frame(2'b00, 2'b00, 10'h2A5, PAT_A), 64);
    expect_val("R2 bank A", 0, 64'(PAT_A));
    expect_val("R2 dimmer", 2, 64'h2A5);
    expect_val("R2 sleep", 3, 64'd0);
    expect_val("R11 sdo low during write", 7, 64'd0);

    write_frame(8'h8E, mk_frame(2'b01, 2'b11, 10'h3FF, PAT_B), 64);
    expect_val("R3 bank B", 1, 64'(PAT_B));
    expect_val("R3 dimmer kept", 2, 64'h2A5);
    expect_val("R3 sleep kept", 3, 64'd0);
    expect_val("R3 bank A kept", 0, 64'(PAT_A));

    write_frame(8'h8E, mk_frame(2'b10, 2'b01, 10'h001, PAT_A2), 64);
    expect_val("R4 bank A kept", 0, 64'(PAT_A));
    expect_val("R4 bank B kept", 1, 64'(PAT_B));
    write_frame(8'h8E, mk_frame(2'b11, 2'b01, 10'h001, PAT_A2), 64);
    expect_val("R4 code 11 bank B kept", 1, 64'(PAT_B));

    write_frame(8'h8E, mk_frame(2'b00, 2'b01, 10'h001, PAT_A2), 63);
    expect_val("R5 short frame", 0, 64'(PAT_A));
    write_frame(8'h8E, mk_frame(2'b00, 2'b01, 10'h001, PAT_A2), 65);
    expect_val("R5 long frame", 0, 64'(PAT_A));
    expect_val("R5 long frame dimmer", 2, 64'h2A5);

    write_frame(8'h8D, mk_frame(2'b00, 2'b01, 10'h001, PAT_A2), 64);
    expect_val("R6 bad address", 0, 64'(PAT_A));
    expect_val("R6 no done", 6, 64'd0);

    write_frame(8'h8E, mk_frame(2'b00, 2'b10, 10'h1FF, PAT_A2), 64);
    expect_val("R2 sleep set", 3, 64'd2);
    expect_val("R2 bank A rewrite", 0, 64'(PAT_A2));

    read_frame(31);
    expect_val("R8 read word with ack", 5, {33'd0, 1'b1, key_bits});
    expect_val("R10 done on full read", 6, 64'd1);
    expect_val("R7 after read", 4, 64'd0);

    key_req = 1'b0;
    read_frame(31);
    expect_val("R9 zero word", 5, 64'd0);
    expect_val("R10 no done without request", 6, 64'd1);

    key_req = 1'b1;
    read_frame(30);
    expect_val("R10 no done on 30 clocks", 6, 64'd1);

    write_frame(8'h8E, mk_frame(2'b00, 2'b00, 10'h1FF, PAT_A2), 64);
    key_bits = 30'h2C3B_19E4;
    read_frame(31);
    expect_val("R8 read word no ack", 5, {33'd0, 1'b0, key_bits});
    expect_val("R10 second done", 6, 64'd2);

    tick(4);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule